// File: doc/BRIEF.md
# RV64 Integer Execute Datapath

This block is the purely combinational integer arithmetic stage of a 64-bit RISC-V core. It receives fields that have already been decoded: the 7-bit major opcode, the 3-bit minor function code, the 7-bit upper function code, two source register values, the PC, and the immediate. The immediate arrives already extracted and sign-extended. The block returns the value to be written back, together with a flag that marks an encoding it does not support.

It handles four groups of operations:

- immediate ALU operations;
- register-register ALU operations;
- the 32-bit "word" forms of add, subtract and shift;
- the two upper-immediate operations.

Word forms compute on the low 32 bits of their operands and always sign-extend bit 31 of the 32-bit result across the upper half. This includes logical right shifts. Loads, stores, branches, jumps, system operations, the register file and any pipelining belong to other blocks.

Top module: `rvx_exec_unit`

## Requirements
- R1: With opcode 0x13, funct3 selects the immediate operation: 0 add, 4 xor, 6 or, 7 and. Each combines rs1 with the immediate. funct7 is ignored for these four.
- R2: Set-less-than writes exactly 1 or 0.
  - funct3 2 (opcode 0x13 or 0x33) compares rs1 with the second operand as signed values.
  - funct3 3 compares them as unsigned values; for opcode 0x13 the second operand is the sign-extended immediate.
- R3: 64-bit shifts use a 6-bit amount: imm[5:0] for opcode 0x13, rs2[5:0] for opcode 0x33.
  - funct3 1 is a left shift. funct3 5 is a right shift.
  - For opcode 0x13, funct7[6:1] must be 0 for a left shift. For a right shift it must be 0 (logical) or 6'h10 (arithmetic). funct7[0] is ignored.
  - For opcode 0x33, funct7 0x00 selects the logical right shift and 0x20 the arithmetic right shift.
- R4: With opcode 0x33 and funct7 0x00, funct3 selects: 0 add, 2 slt, 3 sltu, 4 xor, 6 or, 7 and. funct3 0 with funct7 0x20 is subtract.
- R5: Word forms compute on the low 32 bits and sign-extend bit 31 of the 32-bit result, including logical right shifts.
  - Opcode 0x1b: funct3 0 is add immediate (funct7 ignored), 1 is left shift, 5 is right shift.
  - Opcode 0x3b: funct3 0 is add or subtract, 1 is left shift, 5 is right shift.
  - The shift amount is the low 5 bits of the immediate or of rs2. funct7 must be 0x00, or 0x20 for subtract and arithmetic right shift.
- R6: Opcode 0x37 outputs the immediate unchanged. Opcode 0x17 outputs PC plus the immediate. funct3 and funct7 are ignored for both.
- R7: Any other opcode, funct3 or funct7 combination sets illegal_o to 1 and drives result_o to zero.
- R8: Every encoding listed in R1 to R6 drives illegal_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 7 | Major opcode |
| funct3_i | input | 3 | Minor function code |
| funct7_i | input | 7 | Upper function code (instruction bits 31:25) |
| rs1_i | input | 64 | First source operand |
| rs2_i | input | 64 | Second source operand |
| imm_i | input | 64 | Sign-extended immediate |
| pc_i | input | 64 | Address of the instruction |
| result_o | output | 64 | Write-back value |
| illegal_o | output | 1 | Unsupported encoding |

## Verification
The embedded checks assume that the inputs are settled, two's-complement values with no X bits. This holds because the block has no state and is only evaluated once its inputs are stable. They also assume that the immediate is sign-extended upstream, since the shift-amount and upper-immediate checks read it as given.

The stimulus draws its opcodes from the six supported values plus random ones. funct7 is drawn from 0x00, 0x20, 0x01 and random values, which reaches the rejected encodings. Operands are mixed from random words and the corner values zero, all ones, one, the most negative value and the most positive value. Immediates are random 12-bit sign-extended values or fixed shift amounts of 0, 31, 32 and 63.

// File: rtl/rvx_pkg.sv
package rvx_pkg;
   localparam logic [6:0] OPC_IMM   = 7'h13;
   localparam logic [6:0] OPC_REG   = 7'h33;
   localparam logic [6:0] OPC_IMMW  = 7'h1b;
   localparam logic [6:0] OPC_REGW  = 7'h3b;
   localparam logic [6:0] OPC_LUI   = 7'h37;
   localparam logic [6:0] OPC_AUIPC = 7'h17;

   typedef enum logic [3:0] {
      K_ADD, K_SUB, K_SLL, K_SRL, K_SRA, K_SLT, K_SLTU,
      K_XOR, K_OR, K_AND, K_LUI, K_AUIPC, K_BAD
   } rvx_kind_e;

   typedef struct packed {
      rvx_kind_e kind;
      logic      use_imm;
      logic      word;
   } rvx_ctl_t;
endpackage

// File: rtl/rvx_decode.sv
module rvx_decode
   import rvx_pkg::*;
(
   input  logic [6:0] opcode_i,
   input  logic [2:0] funct3_i,
   input  logic [6:0] funct7_i,
   output rvx_ctl_t   ctl_o
);
   logic base, alt;
   assign base = (funct7_i == 7'h00);
   assign alt  = (funct7_i == 7'h20);

   always_comb begin
      ctl_o = '{kind: K_BAD, use_imm: 1'b0, word: 1'b0};
      unique case (opcode_i)
         OPC_IMM: begin
            ctl_o.use_imm = 1'b1;
            case (funct3_i)
               3'd0: ctl_o.kind = K_ADD;
               3'd1: if (funct7_i[6:1] == 6'h00) ctl_o.kind = K_SLL;
               3'd2: ctl_o.kind = K_SLT;
               3'd3: ctl_o.kind = K_SLTU;
               3'd4: ctl_o.kind = K_XOR;
               3'd5: begin
                  if (funct7_i[6:1] == 6'h00)      ctl_o.kind = K_SRL;
                  else if (funct7_i[6:1] == 6'h10) ctl_o.kind = K_SRA;
               end
               3'd6: ctl_o.kind = K_OR;
               default: ctl_o.kind = K_AND;
            endcase
         end
         OPC_REG: begin
            case (funct3_i)
               3'd0: if (base) ctl_o.kind = K_ADD; else if (alt) ctl_o.kind = K_SUB;
               3'd1: if (base) ctl_o.kind = K_SLL;
               3'd2: if (base) ctl_o.kind = K_SLT;
               3'd3: if (base) ctl_o.kind = K_SLTU;
               3'd4: if (base) ctl_o.kind = K_XOR;
               3'd5: if (base) ctl_o.kind = K_SRL; else if (alt) ctl_o.kind = K_SRA;
               3'd6: if (base) ctl_o.kind = K_OR;
               default: if (base) ctl_o.kind = K_AND;
            endcase
         end
         OPC_IMMW: begin
            ctl_o.use_imm = 1'b1;
            ctl_o.word    = 1'b1;
            case (funct3_i)
               3'd0: ctl_o.kind = K_ADD;
               3'd1: if (base) ctl_o.kind = K_SLL;
               3'd5: if (base) ctl_o.kind = K_SRL; else if (alt) ctl_o.kind = K_SRA;
               default: ctl_o.kind = K_BAD;
            endcase
         end
         OPC_REGW: begin
            ctl_o.word = 1'b1;
            case (funct3_i)
               3'd0: if (base) ctl_o.kind = K_ADD; else if (alt) ctl_o.kind = K_SUB;
               3'd1: if (base) ctl_o.kind = K_SLL;
               3'd5: if (base) ctl_o.kind = K_SRL; else if (alt) ctl_o.kind = K_SRA;
               default: ctl_o.kind = K_BAD;
            endcase
         end
         OPC_LUI:   ctl_o.kind = K_LUI;
         OPC_AUIPC: ctl_o.kind = K_AUIPC;
         default:   ctl_o.kind = K_BAD;
      endcase
   end

   always_comb begin
      // R5
      if (ctl_o.word && ctl_o.kind != K_BAD)
         word_kind_chk: assert (ctl_o.kind inside {K_ADD, K_SUB, K_SLL, K_SRL, K_SRA})
            else $error("word form decoded to a non-word operation");
   end
endmodule

// File: rtl/rvx_shifter.sv
module rvx_shifter #(
   parameter int W = 64,
   localparam int SW = $clog2(W)
) (
   input  logic [W-1:0]  val_i,
   input  logic [SW-1:0] amt_i,
   input  logic          left_i,
   input  logic          arith_i,
   output logic [W-1:0]  out_o
);
   logic [W-1:0] stg [0:SW];
   logic         fill;

   assign fill   = arith_i & val_i[W-1];
   assign stg[0] = val_i;

   for (genvar s = 0; s < SW; s++) begin : g_stage
      localparam int D = 1 << s;
      assign stg[s+1] = !amt_i[s] ? stg[s] :
                        left_i    ? {stg[s][W-1-D:0], {D{1'b0}}} :
                                    {{D{fill}}, stg[s][W-1:D]};
   end

   assign out_o = stg[SW];

   always_comb begin
      // R3
      if (amt_i == '0)
         zero_shift_chk: assert (out_o == val_i)
            else $error("shift by zero changed the value");
   end
endmodule

// File: rtl/rvx_alu.sv
module rvx_alu
   import rvx_pkg::*;
#(
   parameter int XLEN = 64,
   localparam int HW  = XLEN / 2,
   localparam int SW  = $clog2(XLEN)
) (
   input  rvx_ctl_t        ctl_i,
   input  logic [XLEN-1:0] rs1_i,
   input  logic [XLEN-1:0] rs2_i,
   input  logic [XLEN-1:0] imm_i,
   input  logic [XLEN-1:0] pc_i,
   output logic [XLEN-1:0] result_o,
   output logic            illegal_o
);
   logic [XLEN-1:0] opb, sum, full_sh, raw;
   logic [HW-1:0]   half_sh;
   logic            left, arith;

   assign opb   = ctl_i.use_imm ? imm_i : rs2_i;
   assign sum   = (ctl_i.kind == K_SUB) ? rs1_i - opb : rs1_i + opb;
   assign left  = (ctl_i.kind == K_SLL);
   assign arith = (ctl_i.kind == K_SRA);

   rvx_shifter #(.W(XLEN)) u_full_sh (
      .val_i(rs1_i), .amt_i(opb[SW-1:0]), .left_i(left), .arith_i(arith), .out_o(full_sh)
   );
   rvx_shifter #(.W(HW)) u_half_sh (
      .val_i(rs1_i[HW-1:0]), .amt_i(opb[SW-2:0]), .left_i(left), .arith_i(arith), .out_o(half_sh)
   );

   always_comb begin
      unique case (ctl_i.kind)
         K_ADD, K_SUB:        raw = sum;
         K_SLL, K_SRL, K_SRA: raw = ctl_i.word ? {{HW{1'b0}}, half_sh} : full_sh;
         K_SLT:   raw = {{(XLEN-1){1'b0}}, $signed(rs1_i) < $signed(opb)};
         K_SLTU:  raw = {{(XLEN-1){1'b0}}, rs1_i < opb};
         K_XOR:   raw = rs1_i ^ opb;
         K_OR:    raw = rs1_i | opb;
         K_AND:   raw = rs1_i & opb;
         K_LUI:   raw = imm_i;
         K_AUIPC: raw = pc_i + imm_i;
         default: raw = '0;
      endcase
   end

   assign result_o  = ctl_i.word ? {{HW{raw[HW-1]}}, raw[HW-1:0]} : raw;
   assign illegal_o = (ctl_i.kind == K_BAD);

   always_comb begin
      // R5
      if (ctl_i.word)
         word_sext_chk: assert (result_o[XLEN-1:HW] == {HW{result_o[HW-1]}})
            else $error("word result not sign-extended");
   end
endmodule

// File: rtl/rvx_exec_unit.sv
module rvx_exec_unit
   import rvx_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [6:0]      opcode_i,
   input  logic [2:0]      funct3_i,
   input  logic [6:0]      funct7_i,
   input  logic [XLEN-1:0] rs1_i,
   input  logic [XLEN-1:0] rs2_i,
   input  logic [XLEN-1:0] imm_i,
   input  logic [XLEN-1:0] pc_i,
   output logic [XLEN-1:0] result_o,
   output logic            illegal_o
);
   if (XLEN != 64) begin : g_bad_xlen
      $error("rvx_exec_unit: XLEN must be 64 for the word forms");
   end

   rvx_ctl_t ctl;

   rvx_decode u_dec (
      .opcode_i(opcode_i), .funct3_i(funct3_i), .funct7_i(funct7_i), .ctl_o(ctl)
   );

   rvx_alu #(.XLEN(XLEN)) u_alu (
      .ctl_i(ctl), .rs1_i(rs1_i), .rs2_i(rs2_i), .imm_i(imm_i), .pc_i(pc_i),
      .result_o(result_o), .illegal_o(illegal_o)
   );

   always_comb begin
      // R7
      if (illegal_o)
         illegal_zero_chk: assert (result_o == '0)
            else $error("rejected encoding produced a nonzero result");
      // R6
      if (opcode_i == OPC_LUI)
         lui_pass_chk: assert (result_o == imm_i && !illegal_o)
            else $error("upper immediate not passed through");
      // R2
      if ((opcode_i == OPC_IMM || opcode_i == OPC_REG) && funct3_i inside {3'd2, 3'd3} && !illegal_o)
         slt_bool_chk: assert (result_o[XLEN-1:1] == '0)
            else $error("set-less-than result wider than one bit");
      // R8
      if (opcode_i == OPC_AUIPC)
         auipc_legal_chk: assert (!illegal_o)
            else $error("upper-immediate add flagged illegal");
   end
endmodule

// File: tb/rvx_exec_unit_tb.sv
module rvx_exec_unit_tb_top;
   logic        clk = 1'b0;
   logic [6:0]  opc;
   logic [2:0]  f3;
   logic [6:0]  f7;
   logic [63:0] a, b, imm, pc, res;
   logic        ill;
   int          total = 0, bad = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   rvx_exec_unit dut_i (
      .opcode_i(opc), .funct3_i(f3), .funct7_i(f7), .rs1_i(a), .rs2_i(b),
      .imm_i(imm), .pc_i(pc), .result_o(res), .illegal_o(ill)
   );

   function automatic logic [63:0] sx32(input logic [31:0] x);
      return {{32{x[31]}}, x};
   endfunction

   // model returns {illegal, result}; tag names the governing requirement
   function automatic logic [64:0] model(input logic [6:0] o, input logic [2:0] g3,
         input logic [6:0] g7, input logic [63:0] x, input logic [63:0] y,
         input logic [63:0] im, input logic [63:0] p, output string tag);
      logic [63:0] r;
      logic [31:0] t;
      logic ok;
      r = 0; ok = 1'b0; tag = "R7";
      case (o)
         7'h13: begin
            case (g3)
               3'd0: begin r = x + im; ok = 1; tag = "R1"; end
               3'd4: begin r = x ^ im; ok = 1; tag = "R1"; end
               3'd6: begin r = x | im; ok = 1; tag = "R1"; end
               3'd7: begin r = x & im; ok = 1; tag = "R1"; end
               3'd2: begin r = {63'd0, $signed(x) < $signed(im)}; ok = 1; tag = "R2"; end
               3'd3: begin r = {63'd0, x < im}; ok = 1; tag = "R2"; end
               3'd1: if (g7[6:1] == 0) begin r = x << im[5:0]; ok = 1; tag = "R3"; end
               default: begin
                  if (g7[6:1] == 0) begin r = x >> im[5:0]; ok = 1; tag = "R3"; end
                  else if (g7[6:1] == 6'h10) begin r = $signed(x) >>> im[5:0]; ok = 1; tag = "R3"; end
               end
            endcase
         end
         7'h33: begin
            if (g7 == 7'h00) begin
               ok = 1; tag = "R4";
               case (g3)
                  3'd0: r = x + y;
                  3'd1: begin r = x << y[5:0]; tag = "R3"; end
                  3'd2: begin r = {63'd0, $signed(x) < $signed(y)}; tag = "R2"; end
                  3'd3: begin r = {63'd0, x < y}; tag = "R2"; end
                  3'd4: r = x ^ y;
                  3'd5: begin r = x >> y[5:0]; tag = "R3"; end
                  3'd6: r = x | y;
                  default: r = x & y;
               endcase
            end else if (g7 == 7'h20 && g3 == 3'd0) begin r = x - y; ok = 1; tag = "R4"; end
            else if (g7 == 7'h20 && g3 == 3'd5) begin r = $signed(x) >>> y[5:0]; ok = 1; tag = "R3"; end
         end
         7'h1b, 7'h3b: begin
            logic [63:0] s2;
            s2 = (o == 7'h1b) ? im : y;
            if (g3 == 3'd0 && (o == 7'h1b || g7 == 7'h00)) begin t = x[31:0] + s2[31:0]; ok = 1; end
            else if (g3 == 3'd0 && o == 7'h3b && g7 == 7'h20) begin t = x[31:0] - s2[31:0]; ok = 1; end
            else if (g3 == 3'd1 && g7 == 7'h00) begin t = x[31:0] << s2[4:0]; ok = 1; end
            else if (g3 == 3'd5 && g7 == 7'h00) begin t = x[31:0] >> s2[4:0]; ok = 1; end
            else if (g3 == 3'd5 && g7 == 7'h20) begin t = $signed(x[31:0]) >>> s2[4:0]; ok = 1; end
            else t = 0;
            if (ok) begin r = sx32(t); tag = "R5"; end
         end
         7'h37: begin r = im; ok = 1; tag = "R6"; end
         7'h17: begin r = p + im; ok = 1; tag = "R6"; end
         default: ;
      endcase
      return {!ok, r};
   endfunction

   task automatic apply(input logic [6:0] o, input logic [2:0] g3, input logic [6:0] g7,
         input logic [63:0] x, input logic [63:0] y, input logic [63:0] im, input logic [63:0] p);
      logic [64:0] exp;
      string tag;
      @(negedge clk);
      opc = o; f3 = g3; f7 = g7; a = x; b = y; imm = im; pc = p;
      exp = model(o, g3, g7, x, y, im, p, tag);
      @(posedge clk); #1;
      total++;
      if (ill !== exp[64] || res !== exp[63:0]) begin
         bad++;
         $display("FAIL %s: op=%h f3=%0d f7=%h got ill=%b res=%h exp ill=%b res=%h",
                  (exp[64] ? "R7" : tag), o, g3, g7, ill, res, exp[64], exp[63:0]);
         if (!exp[64]) $display("FAIL R8: legal encoding op=%h got ill=%b exp 0", o, ill);
      end
   endtask

   function automatic logic [63:0] pick_val();
      case ($urandom_range(0, 7))
         0: return 64'd0;
         1: return '1;
         2: return 64'd1;
         3: return 64'h8000_0000_0000_0000;
         4: return 64'h7fff_ffff_ffff_ffff;
         5: return 64'h0000_0000_8000_0000;
         default: return {$urandom, $urandom};
      endcase
   endfunction

   function automatic logic [63:0] pick_imm();
      logic [11:0] i12;
      case ($urandom_range(0, 5))
         0: return 64'd0;
         1: return 64'd63;
         2: return 64'd31;
         3: return 64'd32;
         default: begin i12 = 12'($urandom); return {{52{i12[11]}}, i12}; end
      endcase
   endfunction

   initial begin
      #(8 * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got hang exp completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [6:0] ops [0:6];
      logic [6:0] f7s [0:3];
      void'($urandom(32'd2024));
      ops = '{7'h13, 7'h33, 7'h1b, 7'h3b, 7'h37, 7'h17, 7'h00};
      f7s = '{7'h00, 7'h20, 7'h01, 7'h00};
      // R7: all-zero inputs are a rejected opcode
      apply(7'h00, 3'd0, 7'h00, 0, 0, 0, 0);
      // R3: shifts by 0 and 63, arithmetic on most negative
      apply(7'h13, 3'd1, 7'h00, 64'h8000_0000_0000_0001, 0, 64'd0, 0);
      apply(7'h13, 3'd1, 7'h01, 64'd1, 0, 64'd63, 0);
      apply(7'h13, 3'd5, 7'h21, 64'h8000_0000_0000_0000, 0, 64'd63, 0);
      apply(7'h33, 3'd5, 7'h00, 64'h8000_0000_0000_0000, 64'd63, 0, 0);
      apply(7'h33, 3'd5, 7'h20, 64'h8000_0000_0000_0000, 64'hffc0, 0, 0);
      // R2: sltiu with -1 immediate; slt on most negative
      apply(7'h13, 3'd3, 7'h7f, 64'd5, 0, '1, 0);
      apply(7'h33, 3'd2, 7'h00, 64'h8000_0000_0000_0000, 64'd0, 0, 0);
      // R4: subtract wrap
      apply(7'h33, 3'd0, 7'h20, 64'h8000_0000_0000_0000, 64'd1, 0, 0);
      // R5: srlw of a value with bit 31 set, shift by 0 sign-extends
      apply(7'h3b, 3'd5, 7'h00, 64'h0000_0000_8000_0000, 64'd0, 0, 0);
      apply(7'h1b, 3'd5, 7'h20, 64'hffff_ffff_8000_0000, 0, 64'd31, 0);
      apply(7'h1b, 3'd1, 7'h01, 64'd1, 0, 64'd1, 0);
      apply(7'h3b, 3'd0, 7'h00, 64'h0000_0000_7fff_ffff, 64'd1, 0, 0);
      // R6: upper-immediate forms ignore funct fields
      apply(7'h37, 3'd7, 7'h7f, 0, 0, 64'hffff_ffff_8000_0000, 0);
      apply(7'h17, 3'd2, 7'h20, 0, 0, 64'hffff_ffff_ffff_f000, 64'h1000);
      // R1: funct7 ignored for immediate logic ops
      apply(7'h13, 3'd7, 7'h55, 64'hf0f0, 0, 64'hff, 0);
      for (int i = 0; i < 4000; i++) begin
         logic [6:0] o, g7;
         o  = ($urandom_range(0, 9) == 0) ? 7'($urandom) : ops[$urandom_range(0, 6)];
         g7 = ($urandom_range(0, 4) == 0) ? 7'($urandom) : f7s[$urandom_range(0, 3)];
         apply(o, 3'($urandom), g7, pick_val(), pick_val(), pick_imm(), {$urandom, $urandom});
      end
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule